// File: doc/BRIEF.md
# Parallel-In Serial-Out Shift Register

This block is an eight-stage shift register that captures a byte from a parallel bus and sends it out one bit at a time. A serial input feeds the first stage, so several of these registers can be chained to build a longer serial stream. The block drives the value of its last stage and, on a second output, the complement of that value.

Three operating modes exist. Holding the active-low load line LOW copies the parallel bus into all stages, and it overrides everything else. With the load line HIGH, the shift clock and the active-low clock enable are combined by a logical OR into one effective clock. Each rising edge of that effective clock shifts the register by one stage. Because of the OR, a rising enable while the clock is LOW shifts in the same way as a rising clock while the enable is LOW. Holding the enable HIGH freezes the register.

The implementation is fully synchronous to a fast system clock `clk`. The shift clock, enable, serial input and load line pass through a `SYNC_STAGES`-deep sampler. Rising edges of the effective clock are detected from the sampled values. The load takes the bus directly, and the last-stage outputs switch combinationally to the bus during a load, so the serial output follows the bus at once. Each level of `sclk`, `sclk_en_n` and `ser_in` must be held for at least `SYNC_STAGES + 1` system-clock cycles. `ser_in` must be settled at least that long before the effective clock rises.

Top module: `piso_shift_reg`

## Requirements
- R1: While `rst_n` is LOW at a rising `clk` edge and `pload_n` is HIGH, every stage clears to 0, so `q_last` reads 0 and `q_last_n` reads 1.
- R2: While `pload_n` is LOW, stage i takes `par_in[i]` for i = 0..7 on every `clk` edge. The captured byte is kept after `pload_n` returns HIGH.
- R3: While `pload_n` is LOW, `q_last` equals `par_in[7]` combinationally, with no `clk` edge needed.
- R4: With `pload_n` HIGH, a rising edge of (`sclk` OR `sclk_en_n`) shifts the register once. Stage 0 takes `ser_in`, and stage n takes the old stage n-1. The result is visible within `SYNC_STAGES + 2` `clk` cycles.
- R5: After a load, `q_last` presents `par_in[7]` first, then `par_in[6]` down to `par_in[0]` after seven shifts. The eighth shift presents the first bit that was shifted in at `ser_in`.
- R6: With `sclk_en_n` held HIGH and `pload_n` HIGH, any activity on `sclk` or `ser_in` leaves every stage unchanged.
- R7: With `sclk` LOW, a rising `sclk_en_n` shifts exactly like a rising `sclk`. A falling effective clock never shifts.
- R8: Effective-clock rising edges that occur while `pload_n` is LOW are ignored. No shift from them is applied after `pload_n` returns HIGH.
- R9: `q_last_n` is always the inverse of `q_last`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock sampling all inputs |
| rst_n | input | 1 | Synchronous active-low reset |
| pload_n | input | 1 | Active-low parallel load, overrides shifting |
| sclk | input | 1 | Shift clock (rising edge shifts) |
| sclk_en_n | input | 1 | Active-low shift enable, ORed with `sclk` |
| ser_in | input | 1 | Serial data into stage 0 |
| par_in | input | 8 | Parallel data, bit i loads stage i |
| q_last | output | 1 | Value of stage 7 (or `par_in[7]` while loading) |
| q_last_n | output | 1 | Complement of `q_last` |

## Verification
Load and shift can coincide: an effective-clock rising edge can arrive while `pload_n` is still LOW. Because the sampled clock lags the raw load line, a late edge could leak out as a shift just after the load is released. The bench provokes this by raising `sclk` in the middle of a load and only then releasing `pload_n`. It then judges the outcome: `q_last` must still show the loaded `par_in[7]`, and the next genuine shift must reveal `par_in[6]`. A checker property also forbids any shift in the cycle just after the load is released.

// File: rtl/piso_pkg.sv
// Package: shared constants and the per-cycle register mode for the
// parallel-in serial-out shift register.
package piso_pkg;
    localparam int unsigned PISO_WIDTH = 8;
    localparam int unsigned PISO_SYNC  = 2;

    typedef enum logic [1:0] {
        MODE_HOLD  = 2'd0,
        MODE_SHIFT = 2'd1,
        MODE_LOAD  = 2'd2
    } piso_mode_e;
endpackage

// File: rtl/piso_in_sync.sv
// Module: piso_in_sync
// Delays a bundle of N asynchronous inputs through STAGES flops so that
// all of them are sampled with identical latency.
// Assumes: STAGES >= 1; RST_VAL gives each bit's value during reset.
module piso_in_sync #(
    parameter int unsigned N       = 4,
    parameter int unsigned STAGES  = 2,
    parameter logic [N-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] din,
    output logic [N-1:0] dout
);
    logic [N-1:0] pipe [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            // first sampling flop of the chain
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[0] <= RST_VAL;
                else        pipe[0] <= din;
            end
        end else begin : g_rest
            // later flops pass the sample along
            always_ff @(posedge clk) begin
                if (!rst_n) pipe[g] <= RST_VAL;
                else        pipe[g] <= pipe[g-1];
            end
        end
    end

    assign dout = pipe[STAGES-1];
endmodule

// File: rtl/piso_gclk_edge.sv
// Module: piso_gclk_edge
// Forms the effective shift clock as sclk OR enable_n from sampled inputs
// and flags one system-clock cycle per rising edge of it.
// Assumes: inputs already sampled into the clk domain; reset value of the
// history flop is HIGH so a HIGH level at reset exit is not an edge.
module piso_gclk_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_s,
    input  logic en_n_s,
    output logic rise
);
    logic gclk_now;
    logic gclk_prev;

    assign gclk_now = sclk_s | en_n_s;

    // remember the effective clock level of the previous cycle
    always_ff @(posedge clk) begin
        if (!rst_n) gclk_prev <= 1'b1;
        else        gclk_prev <= gclk_now;
    end

    assign rise = gclk_now & ~gclk_prev;
endmodule

// File: rtl/piso_stage_chain.sv
// Module: piso_stage_chain
// W register stages with per-stage load, shift and hold behaviour.
// Assumes: mode is decoded by the parent with load already prioritised.
module piso_stage_chain
    import piso_pkg::*;
#(
    parameter int unsigned W = PISO_WIDTH
) (
    input  logic         clk,
    input  logic         rst_n,
    input  piso_mode_e   mode,
    input  logic [W-1:0] par_d,
    input  logic         ser_d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic shift_src;

        if (i == 0) begin : g_head
            assign shift_src = ser_d;
        end else begin : g_body
            assign shift_src = q[i-1];
        end

        // update one stage according to the decoded mode
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q[i] <= 1'b0;
            end else begin
                unique case (mode)
                    MODE_LOAD:  q[i] <= par_d[i];
                    MODE_SHIFT: q[i] <= shift_src;
                    default:    q[i] <= q[i];
                endcase
            end
        end
    end
endmodule

// File: rtl/piso_shift_reg.sv
// Module: piso_shift_reg (top)
// Parallel-in serial-out shift register. Load is level-sensitive and
// overrides shifting; shifts occur on rising edges of sclk | sclk_en_n.
// Assumes: clk is much faster than sclk / sclk_en_n; every input level is
// held for at least SYNC_STAGES+1 clk cycles.
module piso_shift_reg
    import piso_pkg::*;
#(
    parameter int unsigned W           = PISO_WIDTH,
    parameter int unsigned SYNC_STAGES = PISO_SYNC
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pload_n,
    input  logic         sclk,
    input  logic         sclk_en_n,
    input  logic         ser_in,
    input  logic [W-1:0] par_in,
    output logic         q_last,
    output logic         q_last_n
);
    localparam int unsigned NSYNC = 4;
    // bit order of the sampled bundle: {pload_n, ser_in, sclk_en_n, sclk}
    localparam logic [NSYNC-1:0] SYNC_RST = 4'b0011;

    logic [NSYNC-1:0] raw_bus;
    logic [NSYNC-1:0] smp_bus;
    logic             sclk_s;
    logic             en_n_s;
    logic             ser_s;
    logic             pload_s;
    logic             rise;
    logic             shift_fire;
    piso_mode_e       mode;
    logic [W-1:0]     stage_q;

    assign raw_bus = {pload_n, ser_in, sclk_en_n, sclk};

    piso_in_sync #(
        .N       (NSYNC),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (raw_bus),
        .dout  (smp_bus)
    );

    assign sclk_s  = smp_bus[0];
    assign en_n_s  = smp_bus[1];
    assign ser_s   = smp_bus[2];
    assign pload_s = smp_bus[3];

    piso_gclk_edge u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .sclk_s (sclk_s),
        .en_n_s (en_n_s),
        .rise   (rise)
    );

    // a sampled edge counts only if load was released both then and now
    assign shift_fire = rise & pload_s & pload_n;

    // decode the register mode, load first
    always_comb begin
        if (!pload_n)        mode = MODE_LOAD;
        else if (shift_fire) mode = MODE_SHIFT;
        else                 mode = MODE_HOLD;
    end

    piso_stage_chain #(
        .W (W)
    ) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode),
        .par_d (par_in),
        .ser_d (ser_s),
        .q     (stage_q)
    );

    // during a load the bus top bit is passed straight through
    assign q_last   = pload_n ? stage_q[W-1] : par_in[W-1];
    assign q_last_n = ~q_last;
endmodule

// File: rtl/piso_shift_reg_chk.sv
// Module: piso_shift_reg_chk
// Property checker bound into piso_shift_reg; observes stage state.
module piso_shift_reg_chk #(
    parameter int unsigned W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         pload_n,
    input logic [W-1:0] par_in,
    input logic [W-1:0] stages,
    input logic         shift_fire,
    input logic         ser_s
);
    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pload_n |=> stages == $past(par_in));

    // R4
    shift_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_n && shift_fire) |=> stages == {$past(stages[W-2:0]), $past(ser_s)});

    // R6
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pload_n && !shift_fire) |=> $stable(stages));

    // R8
    load_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(!pload_n) && pload_n) |-> !shift_fire);
endmodule

bind piso_shift_reg piso_shift_reg_chk #(.W(W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .pload_n    (pload_n),
    .par_in     (par_in),
    .stages     (stage_q),
    .shift_fire (shift_fire),
    .ser_s      (ser_s)
);

// File: tb/piso_shift_reg_bench.sv
`timescale 1ns/1ps
module piso_shift_reg_bench;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       pload_n;
    logic       sclk;
    logic       sclk_en_n;
    logic       ser_in;
    logic [7:0] par_in;
    logic       q_last;
    logic       q_last_n;

    int errors = 0;
    int checks = 0;
    logic [7:0] model;

    typedef struct {
        logic  val;
        string req;
    } exp_t;
    exp_t exp_q[$];

    always #2.5 clk = ~clk;

    piso_shift_reg u_piso_shift_reg (
        .clk       (clk),
        .rst_n     (rst_n),
        .pload_n   (pload_n),
        .sclk      (sclk),
        .sclk_en_n (sclk_en_n),
        .ser_in    (ser_in),
        .par_in    (par_in),
        .q_last    (q_last),
        .q_last_n  (q_last_n)
    );

    task automatic check(logic act, logic exp, string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    // monitor: pops one expected item and compares both outputs
    initial begin
        forever begin
            wait (exp_q.size() != 0);
            @(negedge clk);
            begin
                exp_t it;
                it = exp_q.pop_front();
                check(q_last, it.val, it.req);
                check(q_last_n, ~it.val, "R9");
            end
        end
    end

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic expect_out(logic v, string req);
        exp_q.push_back('{v, req});
        wait (exp_q.size() == 0);
        @(negedge clk);
    endtask

    task automatic set_ser(logic s);
        ser_in = s;
        settle();
    endtask

    // drive clock/enable; model a shift on a rising effective clock
    task automatic set_clk(logic c, logic e);
        logic old_g;
        old_g = sclk | sclk_en_n;
        sclk = c;
        sclk_en_n = e;
        if (pload_n && !old_g && (c | e)) model = {model[6:0], ser_in};
        settle();
    endtask

    task automatic do_load(logic [7:0] d);
        pload_n = 1'b0;
        par_in = d;
        #1;
        check(q_last, d[7], "R3 immediate");
        check(q_last_n, ~d[7], "R9 immediate");
        model = d;
        settle();
        pload_n = 1'b1;
        settle();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] fill;
        rst_n = 1'b0; pload_n = 1'b1; sclk = 1'b0; sclk_en_n = 1'b0;
        ser_in = 1'b0; par_in = 8'h00; model = 8'h00;
        repeat (5) @(negedge clk);
        expect_out(1'b0, "R1 in reset");
        rst_n = 1'b1;
        settle();
        expect_out(1'b0, "R1 after reset");

        // load and readout
        do_load(8'hA5);
        expect_out(model[7], "R2 load kept");
        fill = 8'b1100_1010;
        for (int i = 0; i < 8; i++) begin
            set_ser(fill[i]);
            set_clk(1'b1, 1'b0);
            expect_out(model[7], (i < 7) ? "R5 par order" : "R5 first serial bit");
            set_clk(1'b0, 1'b0);
            expect_out(model[7], "R4 falling no shift");
        end
        for (int i = 0; i < 4; i++) begin
            set_ser(~ser_in);
            set_clk(1'b1, 1'b0);
            expect_out(model[7], "R4 fill readout");
            set_clk(1'b0, 1'b0);
        end

        // hold with enable HIGH
        do_load(8'b1011_0011);
        set_clk(1'b1, 1'b0);
        expect_out(model[7], "R4 shift before hold");
        set_clk(1'b1, 1'b1);
        for (int i = 0; i < 3; i++) begin
            set_ser(~ser_in);
            set_clk(1'b0, 1'b1);
            set_clk(1'b1, 1'b1);
            expect_out(model[7], "R6 hold");
        end
        set_clk(1'b1, 1'b0);
        set_clk(1'b0, 1'b0);
        expect_out(model[7], "R6 leave hold");

        // shifting by the enable edge
        do_load(8'b0101_0000);
        set_ser(1'b1);
        set_clk(1'b0, 1'b1);
        expect_out(model[7], "R7 enable edge shift");
        set_clk(1'b0, 1'b0);
        expect_out(model[7], "R7 enable fall no shift");
        set_clk(1'b0, 1'b1);
        expect_out(model[7], "R7 second enable edge");
        set_clk(1'b0, 1'b0);

        // edge during load must be ignored
        pload_n = 1'b0;
        par_in = 8'h5A;
        #1;
        check(q_last, 1'b0, "R3 immediate second");
        model = 8'h5A;
        settle();
        set_ser(1'b1);
        set_clk(1'b1, 1'b0);
        expect_out(1'b0, "R8 during load");
        set_clk(1'b0, 1'b0);
        pload_n = 1'b1;
        settle();
        expect_out(1'b0, "R8 after release");
        set_ser(1'b0);
        set_clk(1'b1, 1'b0);
        expect_out(1'b1, "R8 next shift shows bit 6");
        set_clk(1'b0, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule